// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block derives the SCL timing base of an I2C controller from the peripheral clock. A configuration write loads two packed fields, a pre-divide value and an SCL generation value. It also loads a compensation count for rise time, fall time and internal delay, which is taken from a separate input on the same write. The pre-divider turns the peripheral clock into an internal tick, issued once every 1 + pre-divide input cycles.

The SCL period is counted in internal ticks. It is a fixed base of 20 ticks, plus eight ticks per unit of the SCL generation field, plus the compensation count. The period starts with its high phase. The controller receives the internal tick, the SCL level and two one-cycle strobes that mark the coming phase changes. Driving the enable low parks the divider with SCL high.

Top module: `scl_clk_div`

## Requirements
- R1: After reset, with enable low, `scl_o` is 1 and `tick_o`, `scl_hi_stb_o` and `scl_lo_stb_o` are 0. The configuration resets to all zero.
- R2: When `cfg_we_i` is 1, the block captures its configuration. The pre-divide value comes from `cfg_i[CDF_W-1:0]`. The SCL generation value comes from `cfg_i[CDF_W+5:CDF_W]`. The compensation count comes from `comp_i`.
- R3: While enabled, `tick_o` pulses for one cycle every (pre-divide + 1) clock cycles.
- R4: One SCL period, low phase plus high phase, lasts P = 20 + 8 × SCL generation value + compensation ticks, that is P × (pre-divide + 1) clock cycles.
- R5: Each period begins with a high phase of floor(P/2) ticks. A low phase of P − floor(P/2) ticks follows, so an odd tick goes to the low phase.
- R6: `scl_lo_stb_o` is 1 only in the last cycle before `scl_o` falls. `scl_hi_stb_o` is 1 only in the last cycle before `scl_o` rises.
- R7: A configuration write clears both counters in the cycle after the write. `scl_o` then stays high for exactly floor(P/2) × (pre-divide + 1) cycles, counted from that cycle.
- R8: While `en_i` is 0, `scl_o` is 1 and `tick_o` and both strobes are 0, and both counters are held at zero. When `en_i` rises, a full high phase of floor(P/2) × (pre-divide + 1) cycles begins in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low parks the divider with SCL high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | CDF_W+6 | Packed word: SCL generation value above the pre-divide value |
| comp_i | input | 6 | Rise/fall/delay compensation in ticks, captured on a write |
| tick_o | output | 1 | Internal clock tick enable |
| scl_o | output | 1 | SCL phase level, 1 for the high phase |
| scl_hi_stb_o | output | 1 | One-cycle strobe before the high phase starts |
| scl_lo_stb_o | output | 1 | One-cycle strobe before the low phase starts |

## Verification
A wrong pre-divide count shows within a few cycles as a tick spacing other than pre-divide + 1. It then scales every phase length by the same factor. A period counter that wraps at the wrong point, or a miscomputed half point, shows in the first full phase after a write as a high or low length that is off by whole ticks. A strobe placed one tick early or late shows at the first phase edge. A counter that is not cleared by a write or by the enable shows in the very first high phase measured after that event.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned BASE_TICKS = 20;
  localparam int unsigned STEP_TICKS = 8;
  localparam int unsigned SCGD_W     = 6;
  localparam int unsigned COMP_W     = 6;
endpackage

// File: rtl/scl_prediv.sv
module scl_prediv #(
  parameter int unsigned CDF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CDF_W-1:0] cdf_i,
  output logic             tick_o
);
  logic [CDF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !en_i)    cnt_q <= '0;
    else if (cnt_q == cdf_i)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && !clr_i && (cnt_q == cdf_i);

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cdf_i);
  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cdf_i != '0) |=> !tick_o);
endmodule

// File: rtl/scl_period.sv
module scl_period #(
  parameter int unsigned PER_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_len_i,
  input  logic [PER_W-1:0] hi_len_i,
  output logic             phase_hi_o,
  output logic             hi_stb_o,
  output logic             lo_stb_o
);
  logic [PER_W-1:0] pos_q;
  logic             last_pos;

  assign last_pos = (pos_q == per_len_i - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pos_q <= '0;
    else if (clr_i || !en_i)   pos_q <= '0;
    else if (tick_i)           pos_q <= last_pos ? '0 : pos_q + PER_W'(1);
  end

  assign phase_hi_o = (pos_q < hi_len_i);
  assign hi_stb_o   = tick_i && last_pos;
  assign lo_stb_o   = tick_i && (pos_q == hi_len_i - PER_W'(1));

  // R4
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < per_len_i);
  // R6
  fall_after_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_stb_o |=> $fell(phase_hi_o));
  // R6
  rise_after_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_stb_o |=> $rose(phase_hi_o));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> phase_hi_o && !hi_stb_o && !lo_stb_o);
endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
  import scl_div_pkg::*;
#(
  parameter int unsigned CDF_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    cfg_we_i,
  input  logic [CDF_W+SCGD_W-1:0] cfg_i,
  input  logic [COMP_W-1:0]       comp_i,
  output logic                    tick_o,
  output logic                    scl_o,
  output logic                    scl_hi_stb_o,
  output logic                    scl_lo_stb_o
);
  localparam int unsigned PER_MAX = BASE_TICKS + STEP_TICKS * (2**SCGD_W - 1) + (2**COMP_W - 1);
  localparam int unsigned PER_W   = $clog2(PER_MAX + 1);

  logic [CDF_W-1:0]  cdf_q;
  logic [SCGD_W-1:0] scgd_q;
  logic [COMP_W-1:0] comp_q;
  logic [PER_W-1:0]  per_len, hi_len;
  logic              tick, phase_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cdf_q  <= '0;
      scgd_q <= '0;
      comp_q <= '0;
    end else if (cfg_we_i) begin
      cdf_q  <= cfg_i[CDF_W-1:0];
      scgd_q <= cfg_i[CDF_W +: SCGD_W];
      comp_q <= comp_i;
    end
  end

  assign per_len = PER_W'(BASE_TICKS) + PER_W'(STEP_TICKS) * PER_W'(scgd_q) + PER_W'(comp_q);
  assign hi_len  = per_len >> 1;

  scl_prediv #(.CDF_W(CDF_W)) u_prediv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .clr_i  (cfg_we_i),
    .cdf_i  (cdf_q),
    .tick_o (tick)
  );

  scl_period #(.PER_W(PER_W)) u_period (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .clr_i      (cfg_we_i),
    .tick_i     (tick),
    .per_len_i  (per_len),
    .hi_len_i   (hi_len),
    .phase_hi_o (phase_hi),
    .hi_stb_o   (scl_hi_stb_o),
    .lo_stb_o   (scl_lo_stb_o)
  );

  assign tick_o = tick;
  assign scl_o  = !en_i || phase_hi;

  // R8
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> scl_o && !tick_o);
  // R6
  stb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_hi_stb_o, scl_lo_stb_o}));
endmodule

// File: tb/tb_scl_clk_div.sv
module tb_scl_clk_div;
  localparam int CDF_W = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [CDF_W+5:0]  cfg_i = '0;
  logic [5:0]        comp_i = '0;
  logic              tick_o, scl_o, scl_hi_stb_o, scl_lo_stb_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scl_clk_div #(.CDF_W(CDF_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .cfg_we_i(cfg_we_i),
    .cfg_i(cfg_i), .comp_i(comp_i), .tick_o(tick_o), .scl_o(scl_o),
    .scl_hi_stb_o(scl_hi_stb_o), .scl_lo_stb_o(scl_lo_stb_o)
  );

  function automatic int per_of(int scgd, int comp);
    return 20 + 8 * scgd + comp;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(int cdf, int scgd, int comp);
    @(negedge clk);
    cfg_i    = {6'(scgd), CDF_W'(cdf)};
    comp_i   = 6'(comp);
    cfg_we_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // counts samples while scl_o == lvl; bad counts misplaced strobes (R6)
  task automatic count_lvl(bit lvl, output int n, output int bad);
    bit stb;
    n = 0; bad = 0;
    while (scl_o == lvl && n < 20000) begin
      stb = lvl ? scl_lo_stb_o : scl_hi_stb_o;
      n++;
      @(negedge clk);
      if ((scl_o == lvl) && stb) bad++;
      if ((scl_o != lvl) && !stb) bad++;
    end
  endtask

  task automatic run_case(int cdf, int scgd, int comp);
    int p, hi, lo, d, n, bad, nl, nh, t;
    p = per_of(scgd, comp); hi = p / 2; lo = p - hi; d = cdf + 1;
    wr_cfg(cdf, scgd, comp);
    count_lvl(1'b1, n, bad);
    chk("R7 restart high length", n, hi * d);
    count_lvl(1'b0, nl, bad);
    chk("R5 low phase length", nl, lo * d);
    chk("R6 low-side strobe misplacements", bad, 0);
    count_lvl(1'b1, nh, bad);
    chk("R5 high phase length", nh, hi * d);
    chk("R6 high-side strobe misplacements", bad, 0);
    chk("R4 period length", nl + nh, p * d);
    t = 0;
    while (!tick_o && t < 10) begin @(negedge clk); t++; end
    @(negedge clk);
    t = 1;
    while (!tick_o && t < 10) begin @(negedge clk); t++; end
    chk("R3 tick spacing", t, d);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, bad;
    void'($urandom(32'h5c1d));
    #23;
    chk("R1 scl_o in reset", int'(scl_o), 1);
    chk("R1 tick_o in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", int'(scl_hi_stb_o | scl_lo_stb_o), 0);
    en_i = 1'b1;
    #1;
    // R1 zero config: tick each cycle, P=20
    count_lvl(1'b1, n, bad);
    chk("R1 zero config high length", n, 10);

    // R2 field placement via directed corners
    run_case(0, 0, 0);
    run_case(1, 0, 1);
    run_case(3, 63, 63);
    run_case(2, 5, 0);
    for (int i = 0; i < 8; i++)
      run_case(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
               int'($urandom_range(0, 63)));

    // R8 disable parks high, re-enable starts full high phase
    wr_cfg(1, 2, 3);
    repeat (13) @(negedge clk);
    en_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R8 idle outputs", int'({scl_o, tick_o, scl_hi_stb_o, scl_lo_stb_o}), 8);
    end
    en_i = 1'b1;
    #1;
    count_lvl(1'b1, n, bad);
    chk("R8 high length after re-enable", n, (per_of(2, 3) / 2) * 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule